// File: doc/BRIEF.md
# Five-Channel Dithered Pulse-Width Modulator

The block drives five output pins, each of which can act as a coarse digital-to-analog source. Every channel repeats a cycle of 32 modulator clocks, and the pin is high for the number of clocks set by a 5-bit duty field. A 3-bit dither count adds single-clock pulses to some of the cycles in each group of eight. Averaged over such a group, the output therefore has roughly 8-bit resolution, while the cycles repeat at the rate of a 5-bit modulator. For example, a 20 MHz system clock with the slowest divider gives a 1.25 MHz modulator clock and cycles of about 39.1 kHz.

A prescaler shared by all channels divides the system clock by 2, 4, 8 or 16. The result is a one-cycle tick that advances a slot counter (0..31) and a cycle counter (0..7). Each channel holds a pending data byte and an active data byte. The pending byte is copied to the active byte only when the group of eight cycles ends. A per-pin enable selects either the modulator level or a general-purpose latch value supplied from outside.

Each channel is a small state machine with three states:
- LOW: the pin is low.
- HIGH: the normal high time.
- EXTRA: one inserted dither clock.

Its transitions are:
- cycle start: from any state, enter HIGH when the duty is non-zero. Otherwise enter EXTRA if this cycle is selected for dither, or LOW if it is not.
- high done: leave HIGH for EXTRA or LOW after the last high clock.
- extra done: leave EXTRA for LOW after one clock.
- stay: remain in LOW until the next cycle start.

Top module: `brm_pwm_dac`

## Requirements
- R1: After reset, every data byte, the divider field and every enable are 0, so each pin equals its general-purpose input, including while reset is held.
- R2: A configuration write latches enables from bits 7:3 of the written byte: bit 7 is channel 4, bit 3 is channel 0, and bits 2:0 are ignored. An enabled pin shows the modulator level, and a disabled pin shows `gpio_i` of that bit.
- R3: A control write latches the divider field from bits 1:0. Value d makes one modulator clock last 2^(d+1) system clocks, which is 2, 4, 8 or 16 for d = 0..3.
- R4: A cycle is 32 modulator clocks long. It starts high, and the high time lasts for duty = data bits 7:3 clocks.
- R5: A frame is 8 consecutive cycles. Over one frame, a channel is high for exactly 8*duty + N modulator clocks, where N = data bits 2:0.
- R6: Cycle index c (0..7) in the frame gets one extra high clock when any of these holds: N bit 2 is set and c is odd; N bit 1 is set and c mod 4 = 2; N bit 0 is set and c = 4. The extra clock sits in the slot right after the normal high time (slot number = duty).
- R7: Duty 31 with a dither pulse makes that cycle high for all 32 clocks, so data 0xFF gives 255 high clocks per frame.
- R8: A data write takes effect only from the next frame boundary. The first frame starts at reset release, and the frame during which a write happens keeps the old value.
- R9: Channels are selected by `data_sel` values 0..4 and run independently, each with its own data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_we | input | 1 | Write strobe for a channel data byte |
| data_sel | input | 3 | Channel index for a data write (0..4) |
| data_wdata | input | 8 | Data byte: duty in bits 7:3, dither count in bits 2:0 |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte; bits 1:0 select the divider |
| cfg_we | input | 1 | Write strobe for the pin configuration byte |
| cfg_wdata | input | 8 | Enables in bits 7:3, for channels 4..0 |
| gpio_i | input | 5 | General-purpose latch values for the pins |
| pin_o | output | 5 | Pin levels |

## Verification
Each fault in internal state shows up at the pins within one frame:
- Dither slot selection: a wrong cycle index or dither mapping changes the high count of individual cycles, even when the frame total is right. The bench therefore compares the high count of every cycle of one channel, as well as every frame total.
- Prescaler: a wrong divide ratio scales every count by the wrong factor.
- Data latch timing: a pending byte latched too early changes the total of the frame in which it was written, because the bench writes in the middle of a frame.
- Enable mapping: a wrong enable bit order appears at once as a pin that follows the wrong source.

// File: rtl/brm_pwm_pkg.sv
package brm_pwm_pkg;
    parameter int NCH    = 5;
    parameter int DUTY_W = 5;
    parameter int BRM_W  = 3;
    parameter int DATA_W = DUTY_W + BRM_W;
    parameter int DIV_W  = 2;
    parameter int PRE_W  = 1 << DIV_W;
    parameter int SLOT_W = DUTY_W;
    parameter int CYC_W  = BRM_W;
    parameter int SEL_W  = $clog2(NCH);
    parameter int EN_LSB = DATA_W - NCH;

    typedef enum logic [1:0] {
        CH_LOW   = 2'd0,
        CH_HIGH  = 2'd1,
        CH_EXTRA = 2'd2
    } ch_state_e;

    // Dither selection: bit 2 -> odd cycles, bit 1 -> cycles 2 and 6, bit 0 -> cycle 4
    function automatic logic brm_hit(input logic [CYC_W-1:0] cyc,
                                     input logic [BRM_W-1:0] n);
        logic hit;
        hit = (n[2] && cyc[0])
           || (n[1] && (cyc[1:0] == 2'b10))
           || (n[0] && (cyc == 3'd4));
        return hit;
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import brm_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   lim_w;
    logic [DIV_W:0]   shift_w;

    always_comb begin
        shift_w = {1'b0, div_sel} + 1'b1;
        lim_w   = ({{PRE_W{1'b0}}, 1'b1} << shift_w) - 1'b1;
    end

    assign tick = (pre_q >= lim_w[PRE_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R3: the smallest divide ratio is 2, so two ticks never touch
    p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pwm_sequencer.sv
module pwm_sequencer
    import brm_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot_o,
    output logic [CYC_W-1:0]  cyc_o,
    output logic              cyc_wrap,
    output logic              frame_wrap
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = '1;
    localparam logic [CYC_W-1:0]  CYC_LAST  = '1;

    logic [SLOT_W-1:0] slot_q;
    logic [CYC_W-1:0]  cyc_q;

    assign cyc_wrap   = tick && (slot_q == SLOT_LAST);
    assign frame_wrap = cyc_wrap && (cyc_q == CYC_LAST);
    assign slot_o     = slot_q;
    assign cyc_o      = cyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            cyc_q  <= '0;
        end else if (tick) begin
            slot_q <= slot_q + 1'b1;
            if (slot_q == SLOT_LAST) begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_brm_channel.sv
module pwm_brm_channel
    import brm_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cyc_wrap,
    input  logic              frame_wrap,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [CYC_W-1:0]  cyc_i,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              level_o
);
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] act_q;
    logic [DATA_W-1:0] act_nxt;
    ch_state_e         state_q;
    ch_state_e         state_d;
    logic [SLOT_W-1:0] rem_q;
    logic [SLOT_W-1:0] rem_d;
    logic [DUTY_W-1:0] duty_cur;
    logic [DUTY_W-1:0] duty_nxt;
    logic [BRM_W-1:0]  n_cur;
    logic [BRM_W-1:0]  n_nxt;
    logic [CYC_W-1:0]  cyc_nxt;

    // R8: new data enters only at a frame boundary
    assign act_nxt  = frame_wrap ? shadow_q : act_q;
    assign duty_cur = act_q[DATA_W-1:BRM_W];
    assign n_cur    = act_q[BRM_W-1:0];
    assign duty_nxt = act_nxt[DATA_W-1:BRM_W];
    assign n_nxt    = act_nxt[BRM_W-1:0];
    assign cyc_nxt  = cyc_i + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr_en) begin
                shadow_q <= wr_data;
            end
            act_q <= act_nxt;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_LOW;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        if (tick) begin
            if (cyc_wrap) begin
                // cycle start
                if (duty_nxt != '0) begin
                    state_d = CH_HIGH;
                    rem_d   = duty_nxt - 1'b1;
                end else if (brm_hit(cyc_nxt, n_nxt)) begin
                    state_d = CH_EXTRA;
                end else begin
                    state_d = CH_LOW;
                end
            end else begin
                unique case (state_q)
                    CH_HIGH: begin
                        if (rem_q != '0) begin
                            rem_d = rem_q - 1'b1;
                        end else if (brm_hit(cyc_i, n_cur)) begin
                            state_d = CH_EXTRA;   // high done, dither
                        end else begin
                            state_d = CH_LOW;     // high done
                        end
                    end
                    CH_EXTRA: state_d = CH_LOW;   // extra done
                    CH_LOW:   state_d = CH_LOW;   // stay
                    default:  state_d = CH_LOW;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CH_HIGH:  level_o = 1'b1;
            CH_EXTRA: level_o = 1'b1;
            default:  level_o = 1'b0;
        endcase
    end

    p_high_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HIGH) |-> (slot_i < duty_cur));

    p_extra_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_EXTRA) |-> (slot_i == duty_cur));

    p_frame_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(act_q));
endmodule

// File: rtl/brm_pwm_dac.sv
module brm_pwm_dac
    import brm_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [SEL_W-1:0]  data_sel,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] ctrl_wdata,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [NCH-1:0]    gpio_i,
    output logic [NCH-1:0]    pin_o
);
    logic [DIV_W-1:0]  div_q;
    logic [NCH-1:0]    en_q;
    logic              tick;
    logic [SLOT_W-1:0] slot;
    logic [CYC_W-1:0]  cyc;
    logic              cyc_wrap;
    logic              frame_wrap;
    logic [NCH-1:0]    level;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            en_q  <= '0;
        end else begin
            if (ctrl_we) begin
                div_q <= ctrl_wdata[DIV_W-1:0];
            end
            if (cfg_we) begin
                en_q <= cfg_wdata[DATA_W-1:EN_LSB];
            end
        end
    end

    pwm_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_q),
        .tick    (tick)
    );

    pwm_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .slot_o     (slot),
        .cyc_o      (cyc),
        .cyc_wrap   (cyc_wrap),
        .frame_wrap (frame_wrap)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        pwm_brm_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .cyc_wrap   (cyc_wrap),
            .frame_wrap (frame_wrap),
            .slot_i     (slot),
            .cyc_i      (cyc),
            .wr_en      (data_we && (data_sel == SEL_W'(gi))),
            .wr_data    (data_wdata),
            .level_o    (level[gi])
        );
        assign pin_o[gi] = en_q[gi] ? level[gi] : gpio_i[gi];
    end
endmodule

// File: tb/brm_pwm_dac_tb.sv
module brm_pwm_dac_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_we = 1'b0;
    logic [2:0] data_sel = '0;
    logic [7:0] data_wdata = '0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [4:0] gpio_i = '0;
    logic [4:0] pin_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    localparam int NFRM = 5;

    typedef struct packed {
        logic [4:0][15:0] tot;
        logic [4:0]       duty0;
        logic [2:0]       n0;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    brm_pwm_dac u_dut (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_sel(data_sel),
        .data_wdata(data_wdata), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .gpio_i(gpio_i), .pin_o(pin_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R6 selection rule, written from the requirement
    function automatic int dither(input logic [2:0] n, input int c);
        if (n[2] && (c % 2 == 1)) return 1;
        if (n[1] && (c % 4 == 2)) return 1;
        if (n[0] && (c == 4)) return 1;
        return 0;
    endfunction

    function automatic logic [7:0] pick(input int ph, input int k, input int ch);
        if (k == 0) begin
            case (ch)
                0: return 8'h83;   // duty 16, N 3
                1: return 8'hFF;   // R7 full cycle
                2: return 8'h00;
                3: return 8'h07;   // dither only
                default: return 8'hF8;
            endcase
        end
        return 8'((ph * 37 + k * 53 + ch * 29 + 3) % 256);
    endfunction

    task automatic drive_phase(input int ph, input int p, input int f);
        int j;
        exp_t it;
        j = 0;
        @(negedge clk); j++;
        ctrl_we = 1'b0;
        cfg_we = 1'b1; cfg_wdata = 8'hF8;
        @(negedge clk); j++;
        cfg_we = 1'b0;
        it = '0;
        exp_q.push_back(it);           // frame 0 runs on reset data (R8)
        for (int k = 0; k < NFRM; k++) begin
            while (j < k * f + f / 2) begin
                @(negedge clk); j++;
            end
            it = '0;
            for (int ch = 0; ch < 5; ch++) begin
                logic [7:0] v;
                v = pick(ph, k, ch);
                data_we = 1'b1; data_sel = 3'(ch); data_wdata = v;
                it.tot[ch] = 16'((int'(v[7:3]) * 8 + int'(v[2:0])) * p);
                if (ch == 0) begin
                    it.duty0 = v[7:3];
                    it.n0 = v[2:0];
                end
                @(negedge clk); j++;
            end
            data_we = 1'b0;
            exp_q.push_back(it);       // applies to frame k+1 (R8)
        end
    endtask

    task automatic monitor_phase(input int p, input int f);
        int hi[5];
        int cc[8];
        exp_t it;
        foreach (hi[i]) hi[i] = 0;
        foreach (cc[i]) cc[i] = 0;
        for (int j = 0; j < (NFRM + 1) * f; j++) begin
            for (int ch = 0; ch < 5; ch++) if (pin_o[ch]) hi[ch]++;
            if (pin_o[0]) cc[(j / (32 * p)) % 8]++;
            if ((j + 1) % f == 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 scoreboard empty", 0, 1);
                end else begin
                    it = exp_q.pop_front();
                    for (int ch = 0; ch < 5; ch++)
                        check(hi[ch] == int'(it.tot[ch]),
                              "R3 R5 R7 R8 R9 frame high count", hi[ch], int'(it.tot[ch]));
                    for (int c = 0; c < 8; c++) begin
                        int e;
                        e = (int'(it.duty0) + dither(it.n0, c)) * p;
                        check(cc[c] == e, "R4 R6 cycle high count ch0", cc[c], e);
                    end
                end
                foreach (hi[i]) hi[i] = 0;
                foreach (cc[i]) cc[i] = 0;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_phase(input int d);
        int p;
        int f;
        p = 1 << (d + 1);
        f = 256 * p;
        rst_n = 1'b0; gpio_i = '0; data_we = 1'b0; cfg_we = 1'b0; ctrl_we = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ctrl_we = 1'b1; ctrl_wdata = 8'(d);   // R3 divider in bits 1:0
        fork
            drive_phase(d, p, f);
            monitor_phase(p, f);
        join
    endtask

    initial begin
        // R1 reset state
        gpio_i = 5'b10110;
        repeat (3) @(negedge clk);
        check(pin_o == gpio_i, "R1 pins during reset", int'(pin_o), int'(gpio_i));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pin_o == gpio_i, "R1 pins after reset", int'(pin_o), int'(gpio_i));
        // R2 enable mapping
        cfg_we = 1'b1; cfg_wdata = 8'h08;
        @(negedge clk); cfg_we = 1'b0; gpio_i = 5'b11111;
        @(negedge clk);
        check(pin_o == 5'b11110, "R2 bit3 enables ch0", int'(pin_o), 30);
        cfg_we = 1'b1; cfg_wdata = 8'h80;
        @(negedge clk); cfg_we = 1'b0;
        @(negedge clk);
        check(pin_o == 5'b01111, "R2 bit7 enables ch4", int'(pin_o), 15);
        cfg_we = 1'b1; cfg_wdata = 8'h07;
        @(negedge clk); cfg_we = 1'b0;
        @(negedge clk);
        check(pin_o == 5'b11111, "R2 bits 2:0 ignored", int'(pin_o), 31);
        for (int d = 0; d < 4; d++) run_phase(d);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule